// File: doc/BRIEF.md
# Memory-Mapped GPIO Controller with Interrupt Events

This block controls up to 95 general-purpose pins through a 32-bit register bus with single-cycle writes and combinational reads. There are two groups of registers. Bitmap words hold one bit per pin for the ownership map, the event status and the event enable, with three words per map. Each pin also has two configuration words of its own. These set the output level, the direction, the pin function, the trigger mode, input-sensing disable and a weak-pull code, and they return the synchronized input level.

Each input passes through a two-flop synchronizer and then an event detector. The detector follows the trigger mode chosen for that pin: rising edge, falling edge, low level or high level. Events latch into status bits that software clears by writing ones. A single interrupt output is raised while any pin has both its status bit and its enable bit set. A global control word holds one bit that selects which of two parent interrupt lines the system uses. The ownership map is reset from a parameter, and system firmware uses it to mark pins as reserved.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, the status and enable words read 0, the interrupt output is 0, and every pin's config word 1 reads 0x00000004 (input, native function) while its input is low. Config word 2 reads 0, and the ownership words read `OWN_RESET`, masked to the implemented pins.
- R2: Word k (k = 0..2) of the ownership map is at byte 0x00+4k, of the status map at 0x80+4k, and of the enable map at 0x90+4k. Bit j of word k belongs to pin 32k+j. Bits for pins at or above the pin count read 0. An access whose address bits 1:0 are not zero is ignored and reads 0.
- R3: Config word 1 of pin n is at 0x100+8n. Its bits are: bit 31 output level (RW), bit 30 synchronized input level (read-only, writes ignored), bit 4 trigger kind, bit 3 trigger invert, bit 2 direction (1 = input), bits 1:0 function (1 = GPIO). The input-level bit follows a pin change two clock edges later.
- R4: Config word 2 of pin n is at 0x104+8n. Bit 2 disables input sensing and bits 1:0 hold a pull code. All other bits read 0.
- R5: `pin_oe[n]` is 1 only when the function field of pin n equals 1 and its direction bit is 0. `pin_out[n]` equals bit 31 of that pin's config word 1.
- R6: The trigger mode is {bit 4, bit 3}: 00 rising edge, 01 falling edge, 10 low level, 11 high level. A matching event sets the pin's status bit on the third clock edge after the pin change.
- R7: Writing a status word clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R8: When an event and a clearing write hit the same status bit in the same cycle, the bit stays set. A level-mode status bit sets again while its level is still present.
- R9: While input sensing is disabled, the input-level bit reads 0 and the pin produces no events. Enabling sensing again while the input is steady produces no edge event.
- R10: `irq` is 1 exactly when some pin has both its status bit and its enable bit set. Enable bits are read/write.
- R11: Bit 0 of the global control word at 0x7C drives `irq_sel`. The ownership words are read/write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | NUM_PINS | Asynchronous pin inputs |
| pin_out | output | NUM_PINS | Output levels |
| pin_oe | output | NUM_PINS | Output enables |
| irq | output | 1 | Combined interrupt |
| irq_sel | output | 1 | Parent interrupt line select |

## Verification
Reads are combinational, so the bench samples `bus_rdata` one time step after it sets the address, on a falling clock edge. A register write becomes visible right after the rising edge that takes it. The input-level bit follows a pin change two rising edges later. The status bit and `irq` follow three rising edges later. The bench drives all stimulus on falling edges and counts rising edges to these points before it samples. The same-cycle clear case uses that count to place the write strobe on exactly the edge where the event latches.

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int NUM_PINS = 95,
  parameter int ADDR_W = 10,
  parameter logic [127:0] OWN_RESET = '1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq,
  output logic                irq_sel
);
  localparam int NWORDS = (NUM_PINS + 31) / 32;
  localparam int PADW = NWORDS * 32;
  localparam logic [PADW-1:0] PIN_MASK = ~({PADW{1'b1}} << NUM_PINS);

  logic [PADW-1:0] own_q, sts_q, en_q, clr_vec, ev_pad;
  logic irq_sel_q;
  logic [NUM_PINS-1:0] s1, s2, s3, ev;
  logic [NUM_PINS-1:0] out_q, trig_q, inv_q, dir_q, dis_q;
  logic [1:0] func_q [NUM_PINS];
  logic [1:0] pull_q [NUM_PINS];

  wire aligned = (bus_addr[1:0] == 2'b00);
  wire map_hit = aligned && (bus_addr[ADDR_W-1:8] == '0);
  wire cfg_hit = aligned && (bus_addr[ADDR_W-1:8] != '0);
  wire [5:0] map_w = bus_addr[7:2];
  wire [ADDR_W-4:0] pidx = bus_addr[ADDR_W-1:3] - (ADDR_W-3)'(32);
  wire cfg_hi = bus_addr[2];

  // bitmap maps and global control
  always_comb begin
    clr_vec = '0;
    for (int w = 0; w < NWORDS; w++)
      if (bus_we && map_hit && map_w == 6'(32 + w)) clr_vec[w*32 +: 32] = bus_wdata;
    ev_pad = '0;
    ev_pad[NUM_PINS-1:0] = ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= OWN_RESET[PADW-1:0] & PIN_MASK;
      sts_q <= '0;
      en_q <= '0;
      irq_sel_q <= 1'b0;
    end else begin
      sts_q <= ((sts_q & ~clr_vec) | ev_pad) & PIN_MASK;
      for (int w = 0; w < NWORDS; w++) begin
        if (bus_we && map_hit && map_w == 6'(w))
          own_q[w*32 +: 32] <= bus_wdata & PIN_MASK[w*32 +: 32];
        if (bus_we && map_hit && map_w == 6'(36 + w))
          en_q[w*32 +: 32] <= bus_wdata & PIN_MASK[w*32 +: 32];
      end
      if (bus_we && map_hit && map_w == 6'd31) irq_sel_q <= bus_wdata[0];
    end
  end

  // per-pin synchronizer, configuration and event detection
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    wire sel = cfg_hit && (pidx == (ADDR_W-3)'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1[g] <= 1'b0; s2[g] <= 1'b0; s3[g] <= 1'b0;
        out_q[g] <= 1'b0; trig_q[g] <= 1'b0; inv_q[g] <= 1'b0;
        dir_q[g] <= 1'b1; dis_q[g] <= 1'b0;
        func_q[g] <= 2'd0; pull_q[g] <= 2'd0;
      end else begin
        s1[g] <= pin_in[g];
        s2[g] <= s1[g];
        s3[g] <= s2[g];
        if (bus_we && sel && !cfg_hi) begin
          out_q[g] <= bus_wdata[31];
          trig_q[g] <= bus_wdata[4];
          inv_q[g] <= bus_wdata[3];
          dir_q[g] <= bus_wdata[2];
          func_q[g] <= bus_wdata[1:0];
        end
        if (bus_we && sel && cfg_hi) begin
          dis_q[g] <= bus_wdata[2];
          pull_q[g] <= bus_wdata[1:0];
        end
      end
    end
    assign ev[g] = !dis_q[g] && (trig_q[g] ? (s2[g] == inv_q[g])
                                          : ((s2[g] != s3[g]) && (s2[g] != inv_q[g])));
    assign pin_oe[g] = (func_q[g] == 2'd1) && !dir_q[g];
    assign pin_out[g] = out_q[g];
  end

  // read path
  always_comb begin
    bus_rdata = '0;
    if (map_hit) begin
      if (map_w == 6'd31) bus_rdata = {31'b0, irq_sel_q};
      for (int w = 0; w < NWORDS; w++) begin
        if (map_w == 6'(w)) bus_rdata = own_q[w*32 +: 32];
        if (map_w == 6'(32 + w)) bus_rdata = sts_q[w*32 +: 32];
        if (map_w == 6'(36 + w)) bus_rdata = en_q[w*32 +: 32];
      end
    end else if (cfg_hit) begin
      for (int p = 0; p < NUM_PINS; p++)
        if (pidx == (ADDR_W-3)'(p))
          bus_rdata = cfg_hi ? {29'b0, dis_q[p], pull_q[p]}
                             : {out_q[p], s2[p] & ~dis_q[p], 25'b0,
                                trig_q[p], inv_q[p], dir_q[p], func_q[p]};
    end
  end

  assign irq = |(sts_q & en_q);
  assign irq_sel = irq_sel_q;

  // R6
  rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dis_q[0] && !trig_q[0] && !inv_q[0] && s2[0] && !s3[0]) |=> sts_q[0]);
  // R7
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'('h80) && bus_wdata[0] && !ev[0]) |=> !sts_q[0]);
  // R8
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'('h80) && ev[0]) |=> sts_q[0]);
  // R9
  no_event_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dis_q[0] |=> !$rose(sts_q[0]));
  // R10
  irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (en_q != '0));
  // R10
  en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'('h90)) |=> (en_q[31:0] == $past(bus_wdata)));
endmodule

// File: tb/gpio_irq_ctrl_bench.sv
module gpio_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 95;
  localparam logic [127:0] OWN_INIT = 128'h0000_0000_FFFF_0000_1234_5678_A5A5_0F0F;

  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
  logic [9:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, rv;
  logic [NP-1:0] pins = '0, pin_out, pin_oe;
  logic irq, irq_sel;
  int nchk = 0, nerr = 0;
  bit done = 0;

  gpio_irq_ctrl #(.NUM_PINS(NP), .ADDR_W(10), .OWN_RESET(OWN_INIT)) u_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pins),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq), .irq_sel(irq_sel));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic exp_sts(input int mode, input logic a, input logic b);
    case (mode)
      0: return !a && b;
      1: return a && !b;
      2: return !a || !b;
      default: return a || b;
    endcase
  endfunction

  function automatic logic [9:0] cfg1(input int p); return 10'(32'h100 + 8 * p); endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a);
    bus_addr = a; #1; rv = bus_rdata;
  endtask

  task automatic wait_n(input int n); repeat (n) @(negedge clk); endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    wait_n(3); rst_n = 1'b1; wait_n(1);
    // R1 reset state
    rd(10'h080); chk("R1 status0", rv, 0);
    rd(10'h098); chk("R1 enable2", rv, 0);
    rd(cfg1(40)); chk("R1 cfg1", rv, 32'h4);
    rd(cfg1(40) + 4); chk("R1 cfg2", rv, 0);
    rd(10'h000); chk("R1 own0", rv, 32'hA5A50F0F);
    rd(10'h008); chk("R1 own2 masked", rv, 32'h7FFF0000);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 oe", {31'b0, |pin_oe}, 0);
    // R2 bitmap layout, unimplemented bits, misaligned access
    wr(10'h098, 32'hFFFFFFFF); rd(10'h098); chk("R2 en2 top bit", rv, 32'h7FFFFFFF);
    wr(10'h094, 32'h00C0FFEE); rd(10'h094); chk("R2 en1", rv, 32'h00C0FFEE);
    wr(10'h091, 32'h0); rd(10'h094); chk("R2 misaligned write", rv, 32'h00C0FFEE);
    rd(10'h095); chk("R2 misaligned read", rv, 0);
    wr(10'h094, 0); wr(10'h098, 0);
    // R11 global control and ownership
    wr(10'h07C, 32'h1); chk("R11 irq_sel", {31'b0, irq_sel}, 1);
    wr(10'h004, 32'h0000FFFF); rd(10'h004); chk("R11 own1 rw", rv, 32'h0000FFFF);
    // R3 bit 30 read-only, field readback
    wr(cfg1(10), 32'h4000001D); rd(cfg1(10)); chk("R3 cfg1 ro bit", rv, 32'h0000001D);
    @(negedge clk); pins[10] = 1'b1; wait_n(1); rd(cfg1(10));
    chk("R3 level after 1 edge", rv[30], 0);
    wait_n(1); rd(cfg1(10)); chk("R3 level after 2 edges", rv[30], 1);
    pins[10] = 1'b0; wr(cfg1(10), 32'h4); wait_n(4); wr(10'h080, 32'hFFFFFFFF);
    // R4 config word 2
    wr(cfg1(70) + 4, 32'hFFFFFFFB); rd(cfg1(70) + 4); chk("R4 cfg2", rv, 32'h3);
    wr(cfg1(70) + 4, 0);
    // R5 drive
    wr(cfg1(3), 32'h80000001);
    chk("R5 oe gpio out", {31'b0, pin_oe[3]}, 1); chk("R5 out", {31'b0, pin_out[3]}, 1);
    wr(cfg1(3), 32'h80000000); chk("R5 oe native", {31'b0, pin_oe[3]}, 0);
    wr(cfg1(3), 32'h00000005); chk("R5 oe input", {31'b0, pin_oe[3]}, 0);
    wr(cfg1(3), 32'h4);
    // R6 exact timing, rising edge, pin 5
    wr(10'h080, 32'hFFFFFFFF);
    wr(cfg1(5), 32'h5); wr(10'h090, 32'h20);
    @(negedge clk); pins[5] = 1'b1;
    wait_n(2); rd(10'h080); chk("R6 not yet after 2 edges", rv[5], 0);
    wait_n(1); rd(10'h080); chk("R6 set after 3 edges", rv[5], 1);
    chk("R10 irq on pending", {31'b0, irq}, 1);
    // R7 write one to clear, zero keeps
    wr(10'h080, 32'h0); rd(10'h080); chk("R7 zero keeps", rv[5], 1);
    wr(10'h080, 32'h20); rd(10'h080); chk("R7 one clears", rv[5], 0);
    chk("R10 irq drops", {31'b0, irq}, 0);
    // R8 same-cycle clear loses to new event
    @(negedge clk); pins[5] = 1'b0; wait_n(4);
    @(negedge clk); pins[5] = 1'b1;
    wait_n(2); bus_addr = 10'h080; bus_wdata = 32'h20; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0; rd(10'h080); chk("R8 event wins", rv[5], 1);
    pins[5] = 1'b0; wr(cfg1(5), 32'h4); wr(10'h090, 0);
    // R8 level re-set
    wr(cfg1(7), 32'h1D); @(negedge clk); pins[7] = 1'b1; wait_n(4);
    wr(10'h080, 32'h80); rd(10'h080); chk("R8 level resets", rv[7], 1);
    pins[7] = 1'b0; wait_n(4); wr(10'h080, 32'h80); rd(10'h080); chk("R8 level gone", rv[7], 0);
    wr(cfg1(7), 32'h4);
    // R9 sensing disabled
    wr(cfg1(9), 32'h5); wr(cfg1(9) + 4, 32'h4);
    @(negedge clk); pins[9] = 1'b1; wait_n(5);
    rd(cfg1(9)); chk("R9 level forced 0", rv[30], 0);
    rd(10'h080); chk("R9 no event", rv[9], 0);
    wr(cfg1(9) + 4, 0); wait_n(4);
    rd(10'h080); chk("R9 no edge on re-enable", rv[9], 0);
    rd(cfg1(9)); chk("R9 level after enable", rv[30], 1);
    pins[9] = 1'b0; wr(cfg1(9), 32'h4); wait_n(4);
    // R6 R10 random trigger modes
    for (int i = 0; i < 40; i++) begin
      int p = int'($urandom_range(NP - 1));
      int mode = int'($urandom_range(3));
      logic a = 1'($urandom_range(1));
      logic b = 1'($urandom_range(1));
      logic e = 1'($urandom_range(1));
      logic [9:0] sw = 10'(32'h80 + 4 * (p / 32));
      @(negedge clk); pins[p] = a;
      wr(cfg1(p), 32'(mode * 8 + 5));
      wr(10'(32'h90 + 4 * (p / 32)), 32'(e) << (p % 32));
      wait_n(4);
      wr(10'h080, '1); wr(10'h084, '1); wr(10'h088, '1);
      @(negedge clk); pins[p] = b; wait_n(4);
      rd(sw); chk($sformatf("R6 pin %0d mode %0d", p, mode), rv[p % 32], exp_sts(mode, a, b));
      chk("R10 irq random", {31'b0, irq}, {31'b0, e & exp_sts(mode, a, b)});
      wr(cfg1(p), 32'h4); pins[p] = 1'b0;
      wr(10'(32'h90 + 4 * (p / 32)), 0); wait_n(4);
    end
    done = 1;
    summary();
  end
endmodule